// File: doc/BRIEF.md
# Latched Masked Interrupt Status Block

This block collects two system-control interrupt sources, a brown-out event and a PLL-lock event (expiry of the PLL ready timer), and presents them to the processor as one interrupt line. It keeps three 32-bit words on a simple register bus. The first is a raw status word that records each source event whatever the mask says. The second is a mask word that enables sources. The third is a masked status word.

The masked word is the centre of the block. It is not a combinational AND of raw and mask. Each of its bits is captured when the raw bit and the mask bit are both 1. The bit then stays set until software writes a 1 to it. That write clears the masked bit and the matching raw bit together, so one write acknowledges the whole path.

Bus reads return the word as it stood before any update in the same cycle, one cycle after the request. A source event that lands in the same cycle as a clear is never lost: the raw bit survives the clear, and the masked bit is captured again on the following cycle.

Top module: `sysint_latch`

## Requirements
- R1: After reset the raw, mask and masked words read 0 and `irq` is 0. All interrupts are therefore disabled.
- R2: The raw word is at offset 0x050. Bit 1 sets on a `brownout_evt` pulse and bit 6 sets on a `pll_evt` pulse, whatever the mask holds. Bus writes to this word have no effect.
- R3: The mask word is at offset 0x054 and can be read and written. Only bits 1 and 6 are stored.
- R4: The masked word is at offset 0x058. A masked bit becomes 1 one cycle after its raw bit and its mask bit are both 1. This includes a mask written while the raw bit is already set.
- R5: A masked bit that is set stays set when its mask bit is later written to 0.
- R6: Writing a word to offset 0x058 clears each masked bit whose written bit is 1, and clears the raw bit at the same position. Written 0 bits leave both words unchanged.
- R7: When a source event and a clear of its bit arrive in the same cycle, the raw bit stays set, the masked bit reads 0 for one cycle, and the masked bit is set again on the next cycle.
- R8: Bits 31:7, 5:2 and 0 of every word read 0, and writes to them have no effect. Any other offset reads 0.
- R9: `irq` is the registered OR of the masked bits. It rises two cycles after the event edge when the mask is enabled, and it falls one cycle after the clear.
- R10: A read request sampled at a clock edge returns, after that edge, the word's value from before that edge's update, with `rd_valid` high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data is valid this cycle |
| brownout_evt | input | 1 | Brown-out event pulse |
| pll_evt | input | 1 | PLL ready-timer expiry pulse |
| irq | output | 1 | Interrupt to the processor |

## Verification
The bench builds the block with the default 12-bit offset and the fixed 32-bit word. With a 12-bit offset, the bench can read an offset well outside the three mapped words and confirm that decode rejects it. Because the two live bits sit at positions 1 and 6, with reserved bits between them, all-ones writes can test that writes outside the live bits are dropped and that the set-versus-clear collision happens only at the live bits.

// File: rtl/sysint_pkg.sv
package sysint_pkg;

    localparam int SI_DATA_W = 32;
    localparam int SI_ADDR_W = 12;
    localparam int SI_NSRC   = 2;

    localparam int SI_OFF_RAW  = 32'h050;
    localparam int SI_OFF_MASK = 32'h054;
    localparam int SI_OFF_MIS  = 32'h058;

    typedef logic [SI_DATA_W-1:0] word_t;
    typedef logic [SI_NSRC-1:0]   srcvec_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RAW  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_MIS  = 2'd3
    } regsel_e;

    typedef struct packed {
        regsel_e sel;
        logic    rd;
        logic    wr_mask;
        logic    wr_mis;
    } busdec_t;

    // source index -> bit position in every word (0: brown-out, 1: PLL lock)
    function automatic int src_pos(int idx);
        case (idx)
            0:       return 1;
            default: return 6;
        endcase
    endfunction

    function automatic srcvec_t narrow(word_t w);
        srcvec_t v;
        for (int i = 0; i < SI_NSRC; i++) v[i] = w[src_pos(i)];
        return v;
    endfunction

    function automatic word_t widen(srcvec_t v);
        word_t w;
        w = '0;
        for (int i = 0; i < SI_NSRC; i++) w[src_pos(i)] = v[i];
        return w;
    endfunction

endpackage

// File: rtl/sysint_decode.sv
module sysint_decode
    import sysint_pkg::*;
#(
    parameter int ADDR_W = SI_ADDR_W
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output busdec_t           dec
);
    logic hit_raw, hit_mask, hit_mis;

    always_comb begin
        hit_raw  = (req_addr == ADDR_W'(SI_OFF_RAW));
        hit_mask = (req_addr == ADDR_W'(SI_OFF_MASK));
        hit_mis  = (req_addr == ADDR_W'(SI_OFF_MIS));

        dec         = '0;
        dec.sel     = hit_raw  ? SEL_RAW  :
                      hit_mask ? SEL_MASK :
                      hit_mis  ? SEL_MIS  : SEL_NONE;
        dec.rd      = req_valid && !req_write;
        dec.wr_mask = req_valid && req_write && hit_mask;
        dec.wr_mis  = req_valid && req_write && hit_mis;
    end
endmodule

// File: rtl/sysint_srcbit.sv
module sysint_srcbit (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic mask_we,
    input  logic mask_wbit,
    input  logic clr,
    output logic raw_o,
    output logic mask_o,
    output logic mis_o
);
    logic raw_q, mask_q, mis_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= 1'b0;
            mask_q <= 1'b0;
            mis_q  <= 1'b0;
        end else begin
            // event beats clear so no event is dropped
            if (evt)      raw_q <= 1'b1;
            else if (clr) raw_q <= 1'b0;

            if (mask_we) mask_q <= mask_wbit;

            // sticky capture of raw AND mask; clear drops it for this cycle
            if (clr) mis_q <= 1'b0;
            else     mis_q <= mis_q | (raw_q & mask_q);
        end
    end

    assign raw_o  = raw_q;
    assign mask_o = mask_q;
    assign mis_o  = mis_q;
endmodule

// File: rtl/sysint_readback.sv
module sysint_readback
    import sysint_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  busdec_t dec,
    input  srcvec_t raw,
    input  srcvec_t mask,
    input  srcvec_t mis,
    output word_t   rd_data,
    output logic    rd_valid
);
    word_t sel_word;

    always_comb begin
        unique case (dec.sel)
            SEL_RAW:  sel_word = widen(raw);
            SEL_MASK: sel_word = widen(mask);
            SEL_MIS:  sel_word = widen(mis);
            default:  sel_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= dec.rd;
            rd_data  <= dec.rd ? sel_word : '0;
        end
    end
endmodule

// File: rtl/sysint_latch.sv
module sysint_latch
    import sysint_pkg::*;
#(
    parameter int ADDR_W = SI_ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SI_DATA_W-1:0] req_wdata,
    output logic [SI_DATA_W-1:0] rd_data,
    output logic                 rd_valid,
    input  logic                 brownout_evt,
    input  logic                 pll_evt,
    output logic                 irq
);
    busdec_t dec;
    srcvec_t src_evt, wvec, clr_vec;
    srcvec_t raw_q, mask_q, mis_q;
    logic    irq_q;

    assign src_evt = {pll_evt, brownout_evt};
    assign wvec    = narrow(req_wdata);
    assign clr_vec = dec.wr_mis ? wvec : '0;

    sysint_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .dec       (dec)
    );

    for (genvar i = 0; i < SI_NSRC; i++) begin : g_src
        sysint_srcbit u_bit (
            .clk       (clk),
            .rst       (rst),
            .evt       (src_evt[i]),
            .mask_we   (dec.wr_mask),
            .mask_wbit (wvec[i]),
            .clr       (clr_vec[i]),
            .raw_o     (raw_q[i]),
            .mask_o    (mask_q[i]),
            .mis_o     (mis_q[i])
        );
    end

    sysint_readback u_rb (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .raw      (raw_q),
        .mask     (mask_q),
        .mis      (mis_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |mis_q;
    end

    assign irq = irq_q;
endmodule

// File: rtl/sysint_latch_chk.sv
module sysint_latch_chk
    import sysint_pkg::*;
#(
    parameter int ADDR_W = SI_ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input word_t             req_wdata,
    input srcvec_t           src_evt,
    input srcvec_t           raw_q,
    input srcvec_t           mask_q,
    input srcvec_t           mis_q,
    input logic              irq,
    input word_t             rd_data,
    input logic              rd_valid
);
    logic  mis_wr;
    word_t live;

    assign mis_wr = req_valid && req_write && (req_addr == ADDR_W'(SI_OFF_MIS));
    assign live   = widen('1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (raw_q == '0 && mask_q == '0 && mis_q == '0));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ((rd_data & ~live) == '0));

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        irq == $past(|mis_q));

    for (genvar i = 0; i < SI_NSRC; i++) begin : g_chk
        localparam int P = src_pos(i);

        // R2
        raw_set_chk: assert property (@(posedge clk) disable iff (rst)
            src_evt[i] |=> raw_q[i]);

        // R4
        mis_capture_chk: assert property (@(posedge clk) disable iff (rst)
            (raw_q[i] && mask_q[i] && !(mis_wr && req_wdata[P])) |=> mis_q[i]);

        // R5
        mis_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (mis_q[i] && !(mis_wr && req_wdata[P])) |=> mis_q[i]);

        // R6
        mis_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (mis_wr && req_wdata[P]) |=> !mis_q[i]);

        // R6
        raw_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (mis_wr && req_wdata[P] && !src_evt[i]) |=> !raw_q[i]);

        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (mis_wr && req_wdata[P] && src_evt[i]) |=> raw_q[i]);
    end
endmodule

bind sysint_latch sysint_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .src_evt   (src_evt),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .mis_q     (mis_q),
    .irq       (irq),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
);

// File: tb/sim_sysint_latch.sv
module sim_sysint_latch;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = 12;
    localparam logic [AW-1:0] A_RAW  = 12'h050;
    localparam logic [AW-1:0] A_MASK = 12'h054;
    localparam logic [AW-1:0] A_MIS  = 12'h058;
    localparam logic [AW-1:0] A_NONE = 12'h100;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_EVT = 2'd2;

    localparam int NV = 26;
    localparam logic [1:0]    T_OP   [NV] = '{
        OP_RD, OP_RD, OP_RD, OP_EVT, OP_RD, OP_RD, OP_WR, OP_RD, OP_RD, OP_WR,
        OP_RD, OP_WR, OP_RD, OP_WR,  OP_RD, OP_WR, OP_RD, OP_RD, OP_EVT, OP_RD,
        OP_WR, OP_RD, OP_WR, OP_RD,  OP_RD, OP_RD};
    localparam logic [AW-1:0] T_ADDR [NV] = '{
        A_RAW, A_MASK, A_MIS, A_RAW, A_RAW, A_MIS, A_MASK, A_MASK, A_MIS, A_MASK,
        A_MIS, A_RAW,  A_RAW, A_MIS, A_MIS, A_MIS, A_MIS,  A_RAW,  A_RAW, A_RAW,
        A_MASK, A_MIS, A_MIS, A_RAW, A_NONE, A_MASK};
    // data for writes and events, expected word for reads
    localparam logic [31:0]   T_DATA [NV] = '{
        32'h0, 32'h0, 32'h0, 32'h02, 32'h02, 32'h0, 32'hFFFF_FFFF, 32'h42, 32'h02, 32'h0,
        32'h02, 32'hFFFF_FFFF, 32'h02, 32'hFFFF_FFBD, 32'h02, 32'h02, 32'h0, 32'h0, 32'h40, 32'h40,
        32'h40, 32'h40, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h40};
    // R1 rows 0-2, R2 rows 4/12/19, R4 rows 5/8/21, R3 rows 7/25, R5 row 10,
    // R8 rows 14/24, R6 rows 16/17/23
    localparam int            T_REQ  [NV] = '{
        1, 1, 1, 0, 2, 4, 0, 3, 4, 0,
        5, 0, 2, 0, 8, 0, 6, 6, 0, 2,
        0, 4, 0, 6, 8, 3};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        brownout_evt = 1'b0;
    logic        pll_evt = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sysint_latch #(.ADDR_W(AW)) u0 (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .brownout_evt (brownout_evt),
        .pll_evt      (pll_evt),
        .irq          (irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(logic [AW-1:0] a, output logic [31:0] d, output logic v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic pulse(logic [31:0] which);
        brownout_evt = which[1]; pll_evt = which[6];
        @(negedge clk);
        brownout_evt = 1'b0; pll_evt = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        v;

        idle(3);
        rst = 1'b0;
        idle(1);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R10 rd_valid idle", {31'b0, rd_valid}, 32'h0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            case (T_OP[k])
                OP_WR:  bus_wr(T_ADDR[k], T_DATA[k]);
                OP_EVT: pulse(T_DATA[k]);
                default: begin
                    bus_rd(T_ADDR[k], d, v);
                    check($sformatf("R%0d row %0d", T_REQ[k], k), d, T_DATA[k]);
                end
            endcase
            idle(2);
        end

        // R9: irq timing, mask bits 1 and 6 enabled
        bus_wr(A_MASK, 32'h42);
        idle(1);
        brownout_evt = 1'b1;
        @(negedge clk);            // edge e: raw set
        brownout_evt = 1'b0;
        check("R9 irq low after event edge", {31'b0, irq}, 32'h0);
        @(negedge clk);            // e+1: masked set
        check("R9 irq low one cycle later", {31'b0, irq}, 32'h0);
        @(negedge clk);            // e+2: irq set
        check("R9 irq high two cycles later", {31'b0, irq}, 32'h1);
        bus_wr(A_MIS, 32'h02);     // edge c: masked cleared
        @(negedge clk);            // c+1
        check("R9 irq low after clear", {31'b0, irq}, 32'h0);
        idle(2);

        // R7: event and clear on the same edge
        pulse(32'h02);
        idle(2);
        bus_rd(A_MIS, d, v);
        check("R7 masked set before collision", d, 32'h02);
        brownout_evt = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = A_MIS; req_wdata = 32'h02;
        @(negedge clk);
        brownout_evt = 1'b0; req_write = 1'b0;
        bus_rd(A_MIS, d, v);
        check("R7 masked zero in collision cycle", d, 32'h0);
        bus_rd(A_RAW, d, v);
        check("R7 raw kept on collision", d, 32'h02);
        bus_rd(A_MIS, d, v);
        check("R7 masked recaptured", d, 32'h02);
        bus_wr(A_MIS, 32'h42);
        idle(2);

        // R10: read sampled on the same edge as an event sees the old word
        pll_evt = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = A_RAW;
        @(negedge clk);
        pll_evt = 1'b0; req_valid = 1'b0;
        check("R10 pre-update read data", rd_data, 32'h0);
        check("R10 rd_valid with data", {31'b0, rd_valid}, 32'h1);
        @(negedge clk);
        check("R10 rd_valid single cycle", {31'b0, rd_valid}, 32'h0);
        bus_rd(A_RAW, d, v);
        check("R10 post-update read", d, 32'h40);
        idle(3);
        check("R9 irq from PLL source", {31'b0, irq}, 32'h1);

        // R1: reset mid-run
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        check("R1 irq after mid-run reset", {31'b0, irq}, 32'h0);
        bus_rd(A_RAW, d, v);
        check("R1 raw after mid-run reset", d, 32'h0);
        bus_rd(A_MASK, d, v);
        check("R1 mask after mid-run reset", d, 32'h0);
        bus_rd(A_MIS, d, v);
        check("R1 masked after mid-run reset", d, 32'h0);

        report();
        $finish;
    end
endmodule